// File: doc/BRIEF.md
# Control Endpoint Handshake Controller

This block keeps the control and status state of a device's default control endpoint. It sits between two parties. On one side, firmware reads and writes a single 8-bit control/status word. On the other side, a packet engine reports transaction events: a data packet received with its byte count, an IN data packet sent, a STALL handshake sent, the end of a control transfer, and a bus reset.

From this state the block answers IN tokens with a handshake decision: send the loaded data, send STALL, or NAK. It raises a one-cycle endpoint interrupt request and a one-cycle FIFO flush request. It also latches the received byte count and shows it while a received packet is pending.

Some fields of the word are pulse commands: clear-received and clear-early-end. These are never stored. Others are set by firmware and cleared by hardware. The rest are set by hardware and cleared by firmware.

Top module: `ctl_ep_handshake`

## Requirements
- R1: A receive event while the out-ready bit (bit 0) is clear sets bit 0 and latches the byte count. `rx_count` shows that count while bit 0 is set and reads 0 while bit 0 is clear.
- R2: A receive event while bit 0 is already set is ignored. The count is kept, bit 0 stays set and no interrupt is raised.
- R3: Writing 1 to command bit 6 clears bit 0. Command bits 6 and 7 always read back as 0.
- R4: Writing 1 to bit 1 sets in-ready. A transmit-done event clears it and raises an interrupt, but only if bit 1 was set.
- R5: Writing 1 to bit 5 requests a stall. A stall-sent event clears bit 5 and sets sent-stall (bit 2). Bit 2 holds until firmware writes 1 to bit 2.
- R6: While `in_token` is high, exactly one handshake output is high. It is STALL if bit 5 is set, otherwise data if bit 1 is set, otherwise NAK. With no token, all three are low.
- R7: Writing 1 to bit 3 sets data-end. A control-end event clears bit 3 and raises neither setup-end, flush nor interrupt.
- R8: A control-end event while bit 3 is clear does four things: it sets setup-end (bit 4), pulses `fifo_flush` for one cycle, raises an interrupt, and clears bits 0 and 1. Writing 1 to bit 7 clears bit 4.
- R9: `irq` is a one-cycle pulse in the cycle after an interrupt event, and only when `irq_en` is high.
- R10: A bus-reset event returns every status and command bit, the count, `irq` and `fifo_flush` to 0.
- R11: After reset, the status word, `rx_count`, `irq`, `fifo_flush` and all handshake outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Firmware write strobe for the control/status word |
| wr_data | input | 8 | Firmware write data |
| rd_data | output | 8 | Control/status word readback |
| irq_en | input | 1 | Endpoint interrupt enable |
| irq | output | 1 | Endpoint interrupt request pulse |
| ev_rx_valid | input | 1 | Packet engine: data packet received |
| ev_rx_count | input | CNT_W | Byte count of the received packet |
| ev_tx_done | input | 1 | Packet engine: IN data packet transmitted |
| ev_stall_sent | input | 1 | Packet engine: STALL handshake transmitted |
| ev_ctl_end | input | 1 | Packet engine: control transfer ended |
| ev_bus_reset | input | 1 | Packet engine: bus reset seen |
| in_token | input | 1 | Packet engine: IN token awaiting a handshake decision |
| hs_send_data | output | 1 | Answer the token with the loaded data |
| hs_send_stall | output | 1 | Answer the token with STALL |
| hs_nak | output | 1 | Answer the token with NAK |
| fifo_flush | output | 1 | One-cycle request to flush the shared FIFO |
| rx_count | output | CNT_W | Received byte count, gated by out-ready |

## Verification
The bench builds the block with its default `CNT_W` of 8. This keeps the full range of byte counts small enough to sweep completely. Every value from 0 to 255 is received, shown, and cleared through the command bit, with the interrupt enable toggling on each step. Every combination of stall request, in-ready and token presence is driven against the handshake outputs. The early-end path, the data-end path and bus reset are each started from states that have several bits set, so clearing each bit becomes visible.

// File: rtl/ep0_hs_pkg.sv
package ep0_hs_pkg;
  localparam int CSR_W = 8;

  // bit positions in the control/status word
  localparam int B_OUT_RDY    = 0;
  localparam int B_IN_RDY     = 1;
  localparam int B_STALL_SEEN = 2;
  localparam int B_DATA_END   = 3;
  localparam int B_SETUP_END  = 4;
  localparam int B_STALL_CMD  = 5;
  localparam int B_CLR_OUT    = 6;
  localparam int B_CLR_SETUP  = 7;

  // interrupt source indices
  localparam int IRQ_RX     = 0;
  localparam int IRQ_TX     = 1;
  localparam int IRQ_STALL  = 2;
  localparam int IRQ_EARLY  = 3;
  localparam int N_IRQ_SRC  = 4;

  typedef struct packed {
    logic stall_cmd;
    logic setup_end;
    logic data_end;
    logic stall_seen;
    logic in_ready;
    logic out_ready;
  } ep0_state_t;

  typedef enum logic [1:0] {
    HS_NONE  = 2'd0,
    HS_DATA  = 2'd1,
    HS_STALL = 2'd2,
    HS_NAK   = 2'd3
  } hs_kind_t;

  localparam int N_HS = 3;
endpackage

// File: rtl/ep0_hs_state.sv
module ep0_hs_state
  import ep0_hs_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [CSR_W-1:0]     wr_data,
  input  logic                 ev_rx_valid,
  input  logic [CNT_W-1:0]     ev_rx_count,
  input  logic                 ev_tx_done,
  input  logic                 ev_stall_sent,
  input  logic                 ev_ctl_end,
  input  logic                 ev_bus_reset,
  output ep0_state_t           state,
  output logic [CNT_W-1:0]     count,
  output logic [N_IRQ_SRC-1:0] irq_src,
  output logic                 flush_req
);
  ep0_state_t       st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;
  logic             rx_acc;
  logic             early_set;
  logic             w_in_rdy, w_stall_clr, w_data_end, w_stall_cmd;
  logic             w_clr_out, w_clr_setup;
  logic             unused_wr_bits;

  // decoded firmware writes
  assign w_in_rdy    = wr_en && wr_data[B_IN_RDY];
  assign w_stall_clr = wr_en && wr_data[B_STALL_SEEN];
  assign w_data_end  = wr_en && wr_data[B_DATA_END];
  assign w_stall_cmd = wr_en && wr_data[B_STALL_CMD];
  assign w_clr_out   = wr_en && wr_data[B_CLR_OUT];
  assign w_clr_setup = wr_en && wr_data[B_CLR_SETUP];
  assign unused_wr_bits = wr_data[B_OUT_RDY] ^ wr_data[B_SETUP_END];

  // qualified hardware events
  assign rx_acc    = ev_rx_valid && !st_q.out_ready && !ev_bus_reset;
  assign early_set = ev_ctl_end && !st_q.data_end && !ev_bus_reset;

  always_comb begin
    st_d = st_q;
    if (ev_bus_reset) begin
      st_d = '0;
    end else begin
      // out-ready: hardware set wins over clears
      if (rx_acc)                    st_d.out_ready = 1'b1;
      else if (early_set)            st_d.out_ready = 1'b0;
      else if (w_clr_out)            st_d.out_ready = 1'b0;
      // in-ready: firmware set wins over hardware clears
      if (w_in_rdy)                  st_d.in_ready = 1'b1;
      else if (ev_tx_done)           st_d.in_ready = 1'b0;
      else if (early_set)            st_d.in_ready = 1'b0;
      // sent-stall: hardware set wins over firmware clear
      if (ev_stall_sent)             st_d.stall_seen = 1'b1;
      else if (w_stall_clr)          st_d.stall_seen = 1'b0;
      // stall request: firmware set wins over self-clear
      if (w_stall_cmd)               st_d.stall_cmd = 1'b1;
      else if (ev_stall_sent)        st_d.stall_cmd = 1'b0;
      // data-end: cleared when the transfer ends
      if (w_data_end)                st_d.data_end = 1'b1;
      else if (ev_ctl_end)           st_d.data_end = 1'b0;
      // setup-end: early termination
      if (early_set)                 st_d.setup_end = 1'b1;
      else if (w_clr_setup)          st_d.setup_end = 1'b0;
    end
  end

  assign cnt_en = rx_acc || ev_bus_reset;
  assign cnt_d  = ev_bus_reset ? '0 : ev_rx_count;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= '0;
    else        st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  always_comb begin
    irq_src            = '0;
    irq_src[IRQ_RX]    = rx_acc;
    irq_src[IRQ_TX]    = ev_tx_done && st_q.in_ready && !ev_bus_reset;
    irq_src[IRQ_STALL] = ev_stall_sent && !ev_bus_reset;
    irq_src[IRQ_EARLY] = early_set;
  end

  assign flush_req = early_set;
  assign state     = st_q;
  assign count     = cnt_q;
endmodule

// File: rtl/ep0_hs_decide.sv
module ep0_hs_decide
  import ep0_hs_pkg::*;
(
  input  logic       in_token,
  input  ep0_state_t state,
  output logic [N_HS-1:0] hs_vec
);
  hs_kind_t kind;

  always_comb begin
    if (!in_token)            kind = HS_NONE;
    else if (state.stall_cmd) kind = HS_STALL;
    else if (state.in_ready)  kind = HS_DATA;
    else                      kind = HS_NAK;
  end

  // one-hot decode: index 0 data, 1 stall, 2 nak
  for (genvar k = 0; k < N_HS; k++) begin : g_dec
    assign hs_vec[k] = (kind == hs_kind_t'(k + 1));
  end
endmodule

// File: rtl/ep0_hs_pulse.sv
module ep0_hs_pulse
  import ep0_hs_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 irq_en,
  input  logic [N_IRQ_SRC-1:0] irq_src,
  input  logic                 flush_req,
  output logic                 irq,
  output logic                 fifo_flush
);
  logic irq_q, irq_d;
  logic flush_q, flush_d;

  always_comb begin
    irq_d   = irq_en && (|irq_src);
    flush_d = flush_req;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q   <= 1'b0;
      flush_q <= 1'b0;
    end else begin
      irq_q   <= irq_d;
      flush_q <= flush_d;
    end
  end

  assign irq        = irq_q;
  assign fifo_flush = flush_q;
endmodule

// File: rtl/ctl_ep_handshake.sv
module ctl_ep_handshake
  import ep0_hs_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [7:0]       wr_data,
  output logic [7:0]       rd_data,
  input  logic             irq_en,
  output logic             irq,
  input  logic             ev_rx_valid,
  input  logic [CNT_W-1:0] ev_rx_count,
  input  logic             ev_tx_done,
  input  logic             ev_stall_sent,
  input  logic             ev_ctl_end,
  input  logic             ev_bus_reset,
  input  logic             in_token,
  output logic             hs_send_data,
  output logic             hs_send_stall,
  output logic             hs_nak,
  output logic             fifo_flush,
  output logic [CNT_W-1:0] rx_count
);
  logic                 rst_meta_n, rst_sync_n;
  ep0_state_t           state;
  logic [CNT_W-1:0]     count;
  logic [N_IRQ_SRC-1:0] irq_src;
  logic                 flush_req;
  logic [N_HS-1:0]      hs_vec;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  ep0_hs_state #(.CNT_W(CNT_W)) u_state (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .wr_en        (wr_en),
    .wr_data      (wr_data),
    .ev_rx_valid  (ev_rx_valid),
    .ev_rx_count  (ev_rx_count),
    .ev_tx_done   (ev_tx_done),
    .ev_stall_sent(ev_stall_sent),
    .ev_ctl_end   (ev_ctl_end),
    .ev_bus_reset (ev_bus_reset),
    .state        (state),
    .count        (count),
    .irq_src      (irq_src),
    .flush_req    (flush_req)
  );

  ep0_hs_decide u_decide (
    .in_token(in_token),
    .state   (state),
    .hs_vec  (hs_vec)
  );

  ep0_hs_pulse u_pulse (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .irq_en    (irq_en),
    .irq_src   (irq_src),
    .flush_req (flush_req),
    .irq       (irq),
    .fifo_flush(fifo_flush)
  );

  always_comb begin
    rd_data               = '0;
    rd_data[B_OUT_RDY]    = state.out_ready;
    rd_data[B_IN_RDY]     = state.in_ready;
    rd_data[B_STALL_SEEN] = state.stall_seen;
    rd_data[B_DATA_END]   = state.data_end;
    rd_data[B_SETUP_END]  = state.setup_end;
    rd_data[B_STALL_CMD]  = state.stall_cmd;
  end

  assign hs_send_data  = hs_vec[0];
  assign hs_send_stall = hs_vec[1];
  assign hs_nak        = hs_vec[2];
  assign rx_count      = state.out_ready ? count : '0;
endmodule

// File: rtl/ep0_hs_checker.sv
module ep0_hs_checker #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_ok_n,
  input logic             wr_en,
  input logic [7:0]       wr_data,
  input logic [7:0]       rd_data,
  input logic             irq_en,
  input logic             irq,
  input logic             ev_rx_valid,
  input logic             ev_stall_sent,
  input logic             ev_ctl_end,
  input logic             ev_bus_reset,
  input logic             in_token,
  input logic             hs_send_data,
  input logic             hs_send_stall,
  input logic             hs_nak,
  input logic             fifo_flush,
  input logic [CNT_W-1:0] rx_count
);
  p_count_gate_r1: assert property (@(posedge clk) disable iff (!rst_ok_n)
    !rd_data[0] |-> rx_count == '0);

  p_rx_hold_r2: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (ev_rx_valid && rd_data[0] && !ev_bus_reset && !ev_ctl_end && !(wr_en && wr_data[6]))
      |=> $stable(rx_count) && rd_data[0]);

  p_clr_out_r3: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (wr_en && wr_data[6] && rd_data[0] && !ev_bus_reset) |=> !rd_data[0] && rd_data[7:6] == 2'b00);

  p_stall_done_r5: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (ev_stall_sent && !ev_bus_reset && !(wr_en && wr_data[5])) |=> rd_data[2] && !rd_data[5]);

  p_hs_onehot_r6: assert property (@(posedge clk) disable iff (!rst_ok_n)
    in_token |-> $countones({hs_send_data, hs_send_stall, hs_nak}) == 1);

  p_hs_idle_r6: assert property (@(posedge clk) disable iff (!rst_ok_n)
    !in_token |-> !(hs_send_data || hs_send_stall || hs_nak));

  p_flush_r8: assert property (@(posedge clk) disable iff (!rst_ok_n)
    $rose(rd_data[4]) |-> fifo_flush);

  p_rx_irq_r9: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (ev_rx_valid && !rd_data[0] && !ev_bus_reset && irq_en) |=> irq);

  p_irq_gate_r9: assert property (@(posedge clk) disable iff (!rst_ok_n)
    !irq_en |=> !irq);

  p_bus_reset_r10: assert property (@(posedge clk) disable iff (!rst_ok_n)
    ev_bus_reset |=> rd_data == 8'h00 && rx_count == '0 && !irq && !fifo_flush);
endmodule

bind ctl_ep_handshake ep0_hs_checker #(.CNT_W(CNT_W)) u_chk (
  .clk          (clk),
  .rst_ok_n     (rst_sync_n),
  .wr_en        (wr_en),
  .wr_data      (wr_data),
  .rd_data      (rd_data),
  .irq_en       (irq_en),
  .irq          (irq),
  .ev_rx_valid  (ev_rx_valid),
  .ev_stall_sent(ev_stall_sent),
  .ev_ctl_end   (ev_ctl_end),
  .ev_bus_reset (ev_bus_reset),
  .in_token     (in_token),
  .hs_send_data (hs_send_data),
  .hs_send_stall(hs_send_stall),
  .hs_nak       (hs_nak),
  .fifo_flush   (fifo_flush),
  .rx_count     (rx_count)
);

// File: tb/test_ctl_ep_handshake.sv
`timescale 1ns/1ps
module test_ctl_ep_handshake;
  localparam int CNT_W = 8;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             wr_en;
  logic [7:0]       wr_data;
  logic [7:0]       rd_data;
  logic             irq_en;
  logic             irq;
  logic             ev_rx_valid;
  logic [CNT_W-1:0] ev_rx_count;
  logic             ev_tx_done;
  logic             ev_stall_sent;
  logic             ev_ctl_end;
  logic             ev_bus_reset;
  logic             in_token;
  logic             hs_send_data, hs_send_stall, hs_nak;
  logic             fifo_flush;
  logic [CNT_W-1:0] rx_count;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #2.5 clk = ~clk;

  ctl_ep_handshake #(.CNT_W(CNT_W)) i_ctl_ep_handshake (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .irq_en(irq_en), .irq(irq), .ev_rx_valid(ev_rx_valid), .ev_rx_count(ev_rx_count),
    .ev_tx_done(ev_tx_done), .ev_stall_sent(ev_stall_sent), .ev_ctl_end(ev_ctl_end),
    .ev_bus_reset(ev_bus_reset), .in_token(in_token), .hs_send_data(hs_send_data),
    .hs_send_stall(hs_send_stall), .hs_nak(hs_nak), .fifo_flush(fifo_flush),
    .rx_count(rx_count)
  );

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_wr(input logic [7:0] d);
    wr_en = 1'b1; wr_data = d; step(); wr_en = 1'b0; wr_data = '0;
  endtask
  task automatic do_rx(input logic [CNT_W-1:0] c);
    ev_rx_valid = 1'b1; ev_rx_count = c; step(); ev_rx_valid = 1'b0; ev_rx_count = '0;
  endtask
  task automatic do_tx();
    ev_tx_done = 1'b1; step(); ev_tx_done = 1'b0;
  endtask
  task automatic do_stall_sent();
    ev_stall_sent = 1'b1; step(); ev_stall_sent = 1'b0;
  endtask
  task automatic do_ctl_end();
    ev_ctl_end = 1'b1; step(); ev_ctl_end = 1'b0;
  endtask
  task automatic do_bus_reset();
    ev_bus_reset = 1'b1; step(); ev_bus_reset = 1'b0;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  initial begin
    for (int c = 0; c < 100000; c++) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_data = '0; irq_en = 1'b0;
    ev_rx_valid = 1'b0; ev_rx_count = '0; ev_tx_done = 1'b0; ev_stall_sent = 1'b0;
    ev_ctl_end = 1'b0; ev_bus_reset = 1'b0; in_token = 1'b0;
    repeat (3) step();
    rst_n = 1'b1;
    repeat (4) step();

    // R11 reset state
    check("R11 status", rd_data, 0);
    check("R11 count", rx_count, 0);
    check("R11 irq", irq, 0);
    check("R11 flush", fifo_flush, 0);
    check("R11 hs", {hs_send_data, hs_send_stall, hs_nak}, 0);

    // R1/R2/R3/R9 sweep over every byte count
    for (int i = 0; i < 256; i++) begin
      irq_en = i[0];
      do_rx(CNT_W'(i));
      check("R1 out_ready", rd_data[0], 1);
      check("R1 count", rx_count, i);
      check("R9 irq rx", irq, i[0]);
      if (i % 16 == 0) begin
        do_rx(CNT_W'(~i));
        check("R2 count kept", rx_count, i);
        check("R2 ready kept", rd_data[0], 1);
        check("R2 no irq", irq, 0);
      end
      do_wr(8'h40);
      check("R3 cleared", rd_data[0], 0);
      check("R1 count gated", rx_count, 0);
      check("R3 cmd readback", rd_data[7:6], 0);
    end

    // R9 pulse length
    irq_en = 1'b1;
    do_rx(8'd3);
    check("R9 pulse high", irq, 1);
    step();
    check("R9 pulse low", irq, 0);
    do_wr(8'h40);

    // R6 handshake sweep
    for (int s = 0; s < 4; s++) begin
      for (int t = 0; t < 2; t++) begin
        do_bus_reset();
        if (s[0]) do_wr(8'h02);
        if (s[1]) do_wr(8'h20);
        in_token = t[0];
        #1;
        check("R6 data", hs_send_data, (t == 1 && !s[1] && s[0]) ? 1 : 0);
        check("R6 stall", hs_send_stall, (t == 1 && s[1]) ? 1 : 0);
        check("R6 nak", hs_nak, (t == 1 && !s[1] && !s[0]) ? 1 : 0);
        in_token = 1'b0;
      end
    end
    do_bus_reset();

    // R4 in-ready path
    irq_en = 1'b1;
    do_wr(8'h02);
    check("R4 set", rd_data[1], 1);
    do_tx();
    check("R4 cleared", rd_data[1], 0);
    check("R4 irq", irq, 1);
    do_tx();
    check("R4 no irq when idle", irq, 0);

    // R5 stall path
    do_wr(8'h20);
    check("R5 request", rd_data[5], 1);
    do_stall_sent();
    check("R5 request self-clears", rd_data[5], 0);
    check("R5 sent-stall set", rd_data[2], 1);
    check("R5 irq", irq, 1);
    repeat (3) step();
    check("R5 sent-stall holds", rd_data[2], 1);
    do_wr(8'h04);
    check("R5 sent-stall cleared", rd_data[2], 0);

    // R9 disabled interrupt
    irq_en = 1'b0;
    do_stall_sent();
    check("R9 masked", irq, 0);
    do_wr(8'h04);
    irq_en = 1'b1;

    // R7 data-end path
    do_wr(8'h0A);
    check("R7 set", rd_data[3], 1);
    do_tx();
    check("R7 kept over tx", rd_data[3], 1);
    do_ctl_end();
    check("R7 cleared", rd_data[3], 0);
    check("R7 no setup-end", rd_data[4], 0);
    check("R7 no flush", fifo_flush, 0);
    check("R7 no irq", irq, 0);

    // R8 early end
    do_rx(8'd5);
    do_wr(8'h02);
    do_ctl_end();
    check("R8 setup-end", rd_data[4], 1);
    check("R8 flush", fifo_flush, 1);
    check("R8 irq", irq, 1);
    check("R8 out cleared", rd_data[0], 0);
    check("R8 in cleared", rd_data[1], 0);
    check("R8 count gated", rx_count, 0);
    step();
    check("R8 flush pulse", fifo_flush, 0);
    do_wr(8'h80);
    check("R8 clear", rd_data[4], 0);
    check("R3 cmd7 readback", rd_data[7], 0);

    // R10 bus reset from a busy state
    do_rx(8'd9);
    do_wr(8'h2A);
    do_stall_sent();
    do_wr(8'h20);
    do_ctl_end();
    do_bus_reset();
    check("R10 status", rd_data, 0);
    check("R10 count", rx_count, 0);
    check("R10 irq", irq, 0);
    check("R10 flush", fifo_flush, 0);

    done = 1'b1;
    finish_run();
  end
endmodule